// File: doc/BRIEF.md
# Hash Accelerator Register Front-End

This block is the software-visible face of a hash accelerator. It sits between a CPU register bus and a hash compression core. It decodes word-aligned register accesses for control, status, digest readback, a key byte count, a DMA source address, a DMA byte count and a programmed-I/O data port. It turns control writes into single-cycle start and abort pulses toward the core. It presents the selected algorithm, the last-block flag and the transfer mode to the core. On request it reverses the byte order of input words and of digest words on readback.

The key count, source address and byte count are shadowed. Software may rewrite them while a job runs, and the new values take effect only at the next start. Reads always return the value software last wrote. The core reports completion with a done strobe, and the front-end captures the whole digest on that edge. The number of digest words that read back non-zero follows the 3-bit algorithm code.

Top module: `hash_regfront`

## Requirements
- R1: After reset every register reads zero, and the start, abort and data-valid outputs are low.
- R2: The control word (word address 0x00) stores last-block in bit 5, DMA mode in bit 7, algorithm in bits 10:8, output swap in bit 22 and input swap in bit 23, and reads them back. Start (bit 0) and stop (bit 1) always read as 0.
- R3: Writing 1 to control bit 0 while idle sets busy (status bit 0) and raises `core_start` for exactly one cycle, on the edge after the write. On that same edge the working key count, source address and byte count load from the software copies. The source address has bits 1:0 forced to zero.
- R4: A start write while busy produces no `core_start` pulse and leaves the working values unchanged.
- R5: Writing 1 to control bit 1 clears busy and the data-request flag on the next edge and raises `core_abort` for one cycle. Stop wins over start in the same write.
- R6: Writes to key count (0x48), source address (0x4C) or byte count (0x50) during a job read back at once but do not change the `core_*` working values until the next start.
- R7: `core_done` while busy captures all twelve digest words and clears busy on the same edge. Until then, digest reads return the previous contents.
- R8: Digest word i reads at 0x08+4i. The number of valid words is 5 for algorithm codes 0xx, 8 for 100, 7 for 101, 12 for 111 and 0 for the reserved code 110. Words at or beyond that count read as zero.
- R9: With output swap set, a digest word {b3,b2,b1,b0} reads as {b0,b1,b2,b3}.
- R10: Status bit 16 (data request) is 1 one edge after the block is busy, in CPU-fed mode, with `din_ready` high. A write to the data port (0x54) while it is 1 gives a one-cycle `din_valid` with the word. A write while it is 0 gives no `din_valid`. The data port reads back the last written value.
- R11: With input swap set, the word on `din_data` is the written word with its four bytes reversed.
- R12: Status bit 1 shows `dma_busy` while busy. Status bit 8 latches `dma_err` seen while busy and stays set until the next accepted start. In DMA mode the data request never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| core_start | output | 1 | One-cycle job start pulse |
| core_abort | output | 1 | One-cycle job abort pulse |
| core_mode | output | 3 | Algorithm code |
| core_last | output | 1 | Last-block flag |
| core_dma | output | 1 | DMA mode select |
| core_keycnt | output | 32 | Working key byte count |
| core_saddr | output | 32 | Working DMA source address, word aligned |
| core_bytecnt | output | 32 | Working byte count |
| din_valid | output | 1 | Data word valid toward the core |
| din_data | output | 32 | Data word, optionally byte reversed |
| din_ready | input | 1 | Core can accept a CPU-fed word |
| core_done | input | 1 | Job finished, digest valid |
| core_digest | input | 384 | Twelve digest words, word 0 in the low bits |
| dma_busy | input | 1 | DMA fetcher active |
| dma_err | input | 1 | DMA access error strobe |

## Verification
The bench targets the shadowing corners: a source address rewritten during a job, and a start issued while busy. A design that loads the working copies on every write, or that accepts the second start, shows a changed `core_saddr` or `core_keycnt`, or a stray `core_start`. Each algorithm code is checked at its last valid digest word and at the first word past it, including the reserved code. An off-by-one count leaks a stale word or zeroes a valid one. Data-port writes are made with the request flag both set and clear, and the DMA error flag is checked across a stop and a restart. A design that forwards every write emits a spurious `din_valid`, and a design that clears the error at the wrong time loses it or keeps it.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
   localparam int unsigned B_START  = 0;
   localparam int unsigned B_STOP   = 1;
   localparam int unsigned B_LAST   = 5;
   localparam int unsigned B_DMA    = 7;
   localparam int unsigned B_MODE   = 8;
   localparam int unsigned B_OSWAP  = 22;
   localparam int unsigned B_ISWAP  = 23;
   localparam int unsigned S_BUSY   = 0;
   localparam int unsigned S_DBUSY  = 1;
   localparam int unsigned S_DERR   = 8;
   localparam int unsigned S_REQ    = 16;

   // word index (byte address / 4) of each register
   localparam int unsigned W_CTL    = 0;
   localparam int unsigned W_STS    = 1;
   localparam int unsigned W_DIG0   = 2;
   localparam int unsigned W_KEY    = 18;
   localparam int unsigned W_SADDR  = 19;
   localparam int unsigned W_BCNT   = 20;
   localparam int unsigned W_DIN    = 21;

   function automatic int unsigned digest_words(input logic [2:0] code);
      case (code)
         3'b100:  return 8;
         3'b101:  return 7;
         3'b111:  return 12;
         3'b110:  return 0;
         default: return 5;
      endcase
   endfunction

   function automatic logic [31:0] rev_bytes(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction
endpackage

// File: rtl/hrf_shadow.sv
module hrf_shadow #(
   parameter int N = 3,
   parameter int W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        sw_we,
   input  logic [W-1:0]        sw_wdata,
   input  logic                load,
   output logic [N-1:0][W-1:0] sw_q,
   output logic [N-1:0][W-1:0] work_q
);
   for (genvar i = 0; i < N; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sw_q[i]   <= '0;
            work_q[i] <= '0;
         end else begin
            if (sw_we[i]) sw_q[i] <= sw_wdata;
            if (load) work_q[i] <= sw_q[i];
         end
      end
   end
endmodule

// File: rtl/hrf_digest.sv
module hrf_digest
   import hrf_pkg::*;
#(
   parameter int NW = 12,
   parameter int W  = 32,
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  logic [NW*W-1:0] din,
   input  logic [2:0]    mode,
   input  logic          hit,
   input  logic [IW-1:0] idx,
   input  logic          oswap,
   output logic [W-1:0]  rword
);
   logic [W-1:0] store [NW];
   logic [W-1:0] pick;

   for (genvar i = 0; i < NW; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   store[i] <= '0;
         else if (cap) store[i] <= din[i*W +: W];
      end
   end

   always_comb begin
      pick = '0;
      for (int i = 0; i < NW; i++) begin
         if (hit && idx == IW'(i) && i < int'(digest_words(mode))) pick = store[i];
      end
      rword = oswap ? rev_bytes(pick) : pick;
   end
endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
   import hrf_pkg::*;
#(
   parameter int AW   = 8,
   parameter int DW   = 32,
   parameter int NDIG = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_we,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   output logic            core_start,
   output logic            core_abort,
   output logic [2:0]      core_mode,
   output logic            core_last,
   output logic            core_dma,
   output logic [DW-1:0]   core_keycnt,
   output logic [DW-1:0]   core_saddr,
   output logic [DW-1:0]   core_bytecnt,
   output logic            din_valid,
   output logic [DW-1:0]   din_data,
   input  logic            din_ready,
   input  logic            core_done,
   input  logic [NDIG*DW-1:0] core_digest,
   input  logic            dma_busy,
   input  logic            dma_err
);
   localparam int WIW = AW - 2;
   localparam int NSH = 3;

   if (DW != 32) begin : g_bad_dw
      $error("hash_regfront: byte reversal is defined for 32-bit words only");
   end
   if (NDIG < 12) begin : g_bad_ndig
      $error("hash_regfront: the widest algorithm needs twelve digest words");
   end
   if ((W_DIN + 1) * 4 > (1 << AW)) begin : g_bad_aw
      $error("hash_regfront: address width too small for the register map");
   end

   logic [WIW-1:0] widx;
   assign widx = bus_addr[AW-1:2];

   logic ctl_we, din_we, stop_req, start_acc;
   logic ctl_last, ctl_dma, ctl_oswap, ctl_iswap;
   logic [2:0] ctl_mode;
   logic busy_q, req_q, derr_q, start_q, abort_q, dv_q;
   logic [DW-1:0] din_sw_q, dd_q;

   assign ctl_we    = bus_we && widx == WIW'(W_CTL);
   assign din_we    = bus_we && widx == WIW'(W_DIN);
   assign stop_req  = ctl_we && bus_wdata[B_STOP];
   assign start_acc = ctl_we && bus_wdata[B_START] && !busy_q && !stop_req;

   // control fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_last <= 1'b0; ctl_dma <= 1'b0; ctl_mode <= '0;
         ctl_oswap <= 1'b0; ctl_iswap <= 1'b0;
      end else if (ctl_we) begin
         ctl_last  <= bus_wdata[B_LAST];
         ctl_dma   <= bus_wdata[B_DMA];
         ctl_mode  <= bus_wdata[B_MODE +: 3];
         ctl_oswap <= bus_wdata[B_OSWAP];
         ctl_iswap <= bus_wdata[B_ISWAP];
      end
   end

   // job state and pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0; req_q <= 1'b0; derr_q <= 1'b0;
         start_q <= 1'b0; abort_q <= 1'b0;
      end else begin
         start_q <= start_acc;
         abort_q <= stop_req;
         if (stop_req)                busy_q <= 1'b0;
         else if (start_acc)          busy_q <= 1'b1;
         else if (core_done && busy_q) busy_q <= 1'b0;
         req_q <= busy_q && !stop_req && !core_done && !ctl_dma && din_ready && !din_we;
         if (start_acc)             derr_q <= 1'b0;
         else if (busy_q && dma_err) derr_q <= 1'b1;
      end
   end

   // programmed-I/O data port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         din_sw_q <= '0; dv_q <= 1'b0; dd_q <= '0;
      end else begin
         dv_q <= din_we && req_q;
         if (din_we) din_sw_q <= bus_wdata;
         if (din_we && req_q) dd_q <= ctl_iswap ? rev_bytes(bus_wdata) : bus_wdata;
      end
   end

   // shadowed operation parameters: 0 key count, 1 source address, 2 byte count
   logic [NSH-1:0]         sh_we;
   logic [NSH-1:0][DW-1:0] sh_sw, sh_wk;
   assign sh_we = {bus_we && widx == WIW'(W_BCNT),
                   bus_we && widx == WIW'(W_SADDR),
                   bus_we && widx == WIW'(W_KEY)};

   hrf_shadow #(.N(NSH), .W(DW)) u_shadow (
      .clk(clk), .rst_n(rst_n), .sw_we(sh_we), .sw_wdata(bus_wdata),
      .load(start_acc), .sw_q(sh_sw), .work_q(sh_wk));

   // digest capture and readout
   logic dig_hit;
   logic [WIW-1:0] dig_idx;
   logic [DW-1:0] dig_word;
   assign dig_hit = widx >= WIW'(W_DIG0) && widx < WIW'(W_DIG0 + NDIG);
   assign dig_idx = widx - WIW'(W_DIG0);

   hrf_digest #(.NW(NDIG), .W(DW), .IW(WIW)) u_digest (
      .clk(clk), .rst_n(rst_n), .cap(core_done && busy_q), .din(core_digest),
      .mode(ctl_mode), .hit(dig_hit), .idx(dig_idx), .oswap(ctl_oswap),
      .rword(dig_word));

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (widx == WIW'(W_CTL)) begin
         bus_rdata[B_LAST]      = ctl_last;
         bus_rdata[B_DMA]       = ctl_dma;
         bus_rdata[B_MODE +: 3] = ctl_mode;
         bus_rdata[B_OSWAP]     = ctl_oswap;
         bus_rdata[B_ISWAP]     = ctl_iswap;
      end else if (widx == WIW'(W_STS)) begin
         bus_rdata[S_BUSY]  = busy_q;
         bus_rdata[S_DBUSY] = busy_q && dma_busy;
         bus_rdata[S_DERR]  = derr_q;
         bus_rdata[S_REQ]   = req_q;
      end else if (widx == WIW'(W_KEY))   bus_rdata = sh_sw[0];
      else if (widx == WIW'(W_SADDR))     bus_rdata = sh_sw[1];
      else if (widx == WIW'(W_BCNT))      bus_rdata = sh_sw[2];
      else if (widx == WIW'(W_DIN))       bus_rdata = din_sw_q;
      else if (dig_hit)                   bus_rdata = dig_word;
   end

   assign core_start   = start_q;
   assign core_abort   = abort_q;
   assign core_mode    = ctl_mode;
   assign core_last    = ctl_last;
   assign core_dma     = ctl_dma;
   assign core_keycnt  = sh_wk[0];
   assign core_saddr   = {sh_wk[1][DW-1:2], 2'b00};
   assign core_bytecnt = sh_wk[2];
   assign din_valid    = dv_q;
   assign din_data     = dd_q;
endmodule

// File: rtl/hrf_regfront_chk.sv
module hrf_regfront_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        core_start,
   input logic        core_abort,
   input logic        core_done,
   input logic        din_valid,
   input logic        busy_q,
   input logic        req_q,
   input logic [31:0] core_saddr,
   input logic [31:0] core_keycnt
);
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start); // R3
   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> busy_q); // R3
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> !core_start); // R4
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      core_abort |-> (!busy_q && !req_q)); // R5
   AST_WORK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> ($stable(core_saddr) && $stable(core_keycnt))); // R6
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (core_done && busy_q) |=> !busy_q); // R7
   AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> busy_q); // R10
   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      din_valid |-> $past(req_q)); // R10
endmodule

bind hash_regfront hrf_regfront_chk u_chk (
   .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_abort(core_abort),
   .core_done(core_done), .din_valid(din_valid), .busy_q(busy_q), .req_q(req_q),
   .core_saddr(core_saddr), .core_keycnt(core_keycnt));

// File: tb/hash_regfront_test.sv
module hash_regfront_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_we = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic core_start, core_abort, core_last, core_dma, din_valid;
   logic [2:0] core_mode;
   logic [31:0] core_keycnt, core_saddr, core_bytecnt, din_data;
   logic din_ready = 1'b0, core_done = 1'b0, dma_busy = 1'b0, dma_err = 1'b0;
   logic [12*32-1:0] core_digest = '0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   hash_regfront uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_start(core_start),
      .core_abort(core_abort), .core_mode(core_mode), .core_last(core_last),
      .core_dma(core_dma), .core_keycnt(core_keycnt), .core_saddr(core_saddr),
      .core_bytecnt(core_bytecnt), .din_valid(din_valid), .din_data(din_data),
      .din_ready(din_ready), .core_done(core_done), .core_digest(core_digest),
      .dma_busy(dma_busy), .dma_err(dma_err));

   function automatic logic [31:0] dword(input int i);
      return 32'h0102_0304 + 32'(i) * 32'h1010_1010;
   endfunction

   function automatic logic [31:0] rev(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h00, v); check("R1 ctl", v, 0);
      rd(8'h04, v); check("R1 sts", v, 0);
      rd(8'h48, v); check("R1 key", v, 0);
      rd(8'h08, v); check("R1 digest0", v, 0);
      check("R1 start/abort/valid", {29'b0, core_start, core_abort, din_valid}, 0);
   endtask

   task automatic t_ctl_readback();
      logic [31:0] v;
      wr(8'h00, 32'h00C0_07A3);
      rd(8'h00, v); check("R2 ctl fields", v, 32'h00C0_07A0);
      wr(8'h00, 32'h0);
   endtask

   task automatic t_start_shadow();
      logic [31:0] v;
      wr(8'h48, 32'h11); wr(8'h4C, 32'h1003); wr(8'h50, 32'h40);
      wr(8'h00, 32'h1);
      check("R3 start pulse", {31'b0, core_start}, 1);
      check("R3 saddr aligned", core_saddr, 32'h1000);
      check("R3 keycnt", core_keycnt, 32'h11);
      check("R3 bytecnt", core_bytecnt, 32'h40);
      rd(8'h04, v); check("R3 busy", v & 32'h1, 1);
      check("R3 pulse ends", {31'b0, core_start}, 0);
      wr(8'h4C, 32'h2000);
      check("R6 working saddr held", core_saddr, 32'h1000);
      rd(8'h4C, v); check("R6 saddr readback", v, 32'h2000);
   endtask

   task automatic t_start_busy();
      wr(8'h48, 32'h99);
      wr(8'h00, 32'h1);
      check("R4 no pulse when busy", {31'b0, core_start}, 0);
      check("R4 keycnt held", core_keycnt, 32'h11);
   endtask

   task automatic t_pio();
      logic [31:0] v;
      @(negedge clk); din_ready = 1'b1;
      @(negedge clk);
      rd(8'h04, v); check("R10 request set", v & 32'h0001_0000, 32'h0001_0000);
      wr(8'h00, 32'h0080_0000);
      wr(8'h54, 32'h1122_3344);
      check("R10 valid on write", {31'b0, din_valid}, 1);
      check("R11 input reversed", din_data, 32'h4433_2211);
      @(negedge clk); din_ready = 1'b0;
      @(negedge clk);
      rd(8'h04, v); check("R10 request clear", v & 32'h0001_0000, 0);
      wr(8'h54, 32'h55);
      check("R10 ignored write", {31'b0, din_valid}, 0);
      rd(8'h54, v); check("R10 port readback", v, 32'h55);
   endtask

   task automatic t_stop();
      logic [31:0] v;
      @(negedge clk); din_ready = 1'b1;
      @(negedge clk); @(negedge clk);
      wr(8'h00, 32'h2);
      check("R5 abort pulse", {31'b0, core_abort}, 1);
      rd(8'h04, v); check("R5 idle after stop", v, 0);
      din_ready = 1'b0;
   endtask

   task automatic t_done_digest();
      logic [31:0] v;
      for (int i = 0; i < 12; i++) core_digest[i*32 +: 32] = dword(i);
      wr(8'h00, 32'h401);
      rd(8'h08, v); check("R7 digest before done", v, 0);
      @(negedge clk); core_done = 1'b1;
      @(negedge clk); core_done = 1'b0;
      rd(8'h04, v); check("R7 busy clears on done", v & 32'h1, 0);
      rd(8'h08, v); check("R8 sha256 w0", v, dword(0));
      rd(8'h24, v); check("R8 sha256 w7", v, dword(7));
      rd(8'h28, v); check("R8 sha256 w8 zero", v, 0);
      wr(8'h00, 32'h500);
      rd(8'h20, v); check("R8 sha224 w6", v, dword(6));
      rd(8'h24, v); check("R8 sha224 w7 zero", v, 0);
      wr(8'h00, 32'h700);
      rd(8'h34, v); check("R8 sha384 w11", v, dword(11));
      wr(8'h00, 32'h300);
      rd(8'h18, v); check("R8 sha1 w4", v, dword(4));
      rd(8'h1C, v); check("R8 sha1 w5 zero", v, 0);
      wr(8'h00, 32'h600);
      rd(8'h08, v); check("R8 reserved zero", v, 0);
      wr(8'h00, 32'h0040_0400);
      rd(8'h0C, v); check("R9 output reversed", v, rev(dword(1)));
      wr(8'h00, 32'h0);
   endtask

   task automatic t_dma();
      logic [31:0] v;
      din_ready = 1'b1;
      wr(8'h00, 32'h81);
      @(negedge clk); dma_busy = 1'b1; dma_err = 1'b1;
      @(negedge clk); dma_err = 1'b0;
      rd(8'h04, v); check("R12 dma busy and error", v, 32'h0000_0103);
      wr(8'h00, 32'h82);
      rd(8'h04, v); check("R12 error kept after stop", v, 32'h0000_0100);
      wr(8'h00, 32'h81);
      rd(8'h04, v); check("R12 error cleared by start", v, 32'h0000_0003);
      wr(8'h00, 32'h82);
      dma_busy = 1'b0; din_ready = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctl_readback();
      t_start_shadow();
      t_start_busy();
      t_pio();
      t_stop();
      t_done_digest();
      t_dma();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule